// File: doc/BRIEF.md
# Edge-Latched External Interrupt Controller

This block gathers eight external interrupt pins for a processor core. Seven of them carry a software-programmed priority level, and the eighth is a non-maskable source whose level is fixed at 7. Each pin passes through a two-flop synchronizer. While its enable bit from the port-control logic is set, a high-to-low transition on the pin latches two flags. The pending flag is what the core sees, and the core's acknowledge clears it. The trace flag is a record of the event that only software can remove.

The controller always presents the highest level among the pending sources to the core. When the core acknowledges a level, the controller returns an auto-vector number for that level in the same cycle, in the range 25 to 31, and clears the pending flag of the source being served. Software reaches the levels and flags through a byte-wide register port. Four level registers each hold two sources, and one further register holds the trace flags.

Top module: `eint_ctrl`

## Requirements
- R1: After a falling edge on an enabled pin, the source's pending flag and trace flag both read 1 on the third rising clock edge. A pin held low sets each flag only once.
- R2: A pin whose bit in `en_i` is 0 sets no flag, whatever edges it makes.
- R3: Address k (k = 0..3) holds source 2k in bits 3:0 and source 2k+1 in bits 7:4. Within each nibble, the top bit is the pending flag and the low three bits are the level. The level of source 7, the non-maskable input, always reads 3'b111 and cannot be written.
- R4: Writing 0 to a pending bit clears that flag. Writing 1 leaves the flag unchanged. A write also loads the levels of both sources in the addressed register.
- R5: Address 4 holds the trace flags, with bit n belonging to source n. Writing 0 to a bit clears it and writing 1 has no effect. An acknowledge never changes a trace flag.
- R6: `irq_lvl_o` carries the highest level found among the pending sources. It is 0 when no source is pending. A pending source whose level is 0 makes no request.
- R7: A cycle with `ack_i` high and a nonzero `ack_lvl_i` clears the pending flag of the lowest-numbered pending source at that level. In the same cycle, `vec_vld_o` goes high and `vec_o` equals 24 + `ack_lvl_i`. If no pending source has that level, `vec_vld_o` stays low and no flag changes.
- R8: When a new edge arrives in the same cycle as an acknowledge or a software clear of the same flag, the flag ends up set.
- R9: Out of reset, all flags are 0, all programmable levels are 0, `irq_lvl_o` is 0 and `vec_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n_i | input | 8 | Raw interrupt pins, active on the falling edge; bit 7 is the non-maskable input |
| en_i | input | 8 | Per-pin enable from the port control |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` |
| irq_lvl_o | output | 3 | Highest pending request level |
| ack_i | input | 1 | Acknowledge strobe from the core |
| ack_lvl_i | input | 3 | Level being acknowledged |
| vec_vld_o | output | 1 | Acknowledge matched a pending source |
| vec_o | output | 8 | Auto-vector number |

## Verification
Two events can target the same flag in one cycle. One is the detection of a new edge. The other is its removal, either by an acknowledge of the source's level or by a software write of 0. The bench first latches a flag and then drops the pin again. It times the acknowledge, or the register write, to land on exactly the clock edge where the synchronized edge is detected, three edges after the pin falls. It then reads the flag back through the level register and expects 1. A plain acknowledge without a new edge serves as the control case and must clear the flag.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int EINT_NSRC     = 8;
  localparam int EINT_LVL_W    = 3;
  localparam int EINT_ADDR_W   = 3;
  localparam int EINT_DATA_W   = 8;
  localparam int EINT_TRACE_AD = 4;
  localparam int EINT_VEC_W    = 8;
  localparam int EINT_VEC_L1   = 25;
  localparam int EINT_SYNC     = 2;
endpackage

// File: rtl/eint_sync_edge.sv
module eint_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  input  logic en_i,
  output logic fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[DEPTH-2:0], pin_n_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  // previous synchronized value high, current low
  assign fall_o = en_i & sh_q[DEPTH-1] & ~sh_q[DEPTH-2];
endmodule

// File: rtl/eint_arb.sv
module eint_arb #(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3
) (
  input  logic [NSRC-1:0]       pend_i,
  input  logic [NSRC*LVL_W-1:0] lvl_flat_i,
  input  logic [LVL_W-1:0]      ack_lvl_i,
  output logic [LVL_W-1:0]      max_lvl_o,
  output logic                  ack_hit_o,
  output logic [NSRC-1:0]       ack_sel_o
);
  always_comb begin
    logic [LVL_W-1:0] lv;
    max_lvl_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      lv = lvl_flat_i[i*LVL_W +: LVL_W];
      if (pend_i[i] && (lv > max_lvl_o)) max_lvl_o = lv;
    end
  end

  always_comb begin
    logic [LVL_W-1:0] lw;
    ack_sel_o = '0;
    ack_hit_o = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      lw = lvl_flat_i[i*LVL_W +: LVL_W];
      if (!ack_hit_o && pend_i[i] && (lw == ack_lvl_i) && (ack_lvl_i != '0)) begin
        ack_sel_o[i] = 1'b1;
        ack_hit_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/eint_regs.sv
module eint_regs #(
  parameter int NSRC     = 8,
  parameter int LVL_W    = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int TRACE_AD = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       fall_i,
  input  logic [NSRC-1:0]       ack_clr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [NSRC-1:0]       pend_o,
  output logic [NSRC-1:0]       trace_o,
  output logic [NSRC*LVL_W-1:0] lvl_flat_o,
  output logic [DATA_W-1:0]     rdata_o
);
  localparam int NPROG = NSRC - 1;
  localparam int NREG  = NSRC / 2;
  localparam int NIB   = DATA_W / 2;

  logic [LVL_W-1:0] lvl_q   [NPROG];
  logic [LVL_W-1:0] lvl_d   [NPROG];
  logic [NPROG-1:0] lvl_we;
  logic [LVL_W-1:0] lvl_all [NSRC];
  logic [NSRC-1:0]  pend_q, pend_d, pend_clr;
  logic [NSRC-1:0]  trace_q, trace_d, trace_clr;
  logic             trace_sel;

  assign trace_sel = wr_en_i && (addr_i == ADDR_W'(TRACE_AD));

  always_comb begin
    for (int i = 0; i < NPROG; i++) begin
      lvl_we[i] = wr_en_i && (addr_i == ADDR_W'(i / 2));
      lvl_d[i]  = wdata_i[(i % 2) * NIB +: LVL_W];
    end
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      if (g == NSRC - 1) begin : g_fixed
        assign lvl_all[g] = '1;
      end else begin : g_prog
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)         lvl_q[g] <= '0;
          else if (lvl_we[g]) lvl_q[g] <= lvl_d[g];
        end
        assign lvl_all[g] = lvl_q[g];
      end
      assign lvl_flat_o[g*LVL_W +: LVL_W] = lvl_all[g];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      pend_clr[i]  = wr_en_i && (addr_i == ADDR_W'(i / 2)) &&
                     !wdata_i[(i % 2) * NIB + NIB - 1];
      trace_clr[i] = trace_sel && !wdata_i[i];
    end
    // a fresh edge overrides any clear in the same cycle
    pend_d  = fall_i | (pend_q & ~ack_clr_i & ~pend_clr);
    trace_d = fall_i | (trace_q & ~trace_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      trace_q <= '0;
    end else begin
      pend_q  <= pend_d;
      trace_q <= trace_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (addr_i == ADDR_W'(r))
        rdata_o = {pend_q[2*r+1], lvl_all[2*r+1], pend_q[2*r], lvl_all[2*r]};
    end
    if (addr_i == ADDR_W'(TRACE_AD)) rdata_o = trace_q;
  end

  assign pend_o  = pend_q;
  assign trace_o = trace_q;
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl import eint_pkg::*; #(
  parameter int NSRC     = EINT_NSRC,
  parameter int LVL_W    = EINT_LVL_W,
  parameter int ADDR_W   = EINT_ADDR_W,
  parameter int DATA_W   = EINT_DATA_W,
  parameter int TRACE_AD = EINT_TRACE_AD,
  parameter int VEC_W    = EINT_VEC_W,
  parameter int VEC_L1   = EINT_VEC_L1,
  parameter int SYNC     = EINT_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pin_n_i,
  input  logic [NSRC-1:0]   en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  input  logic              ack_i,
  input  logic [LVL_W-1:0]  ack_lvl_i,
  output logic              vec_vld_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [1:0]              rst_sq;
  logic                    rst_l;
  logic [NSRC-1:0]         fall;
  logic [NSRC-1:0]         pend_q;
  logic [NSRC-1:0]         trace_q;
  logic [NSRC*LVL_W-1:0]   lvl_flat;
  logic [NSRC-1:0]         ack_sel;
  logic [NSRC-1:0]         ack_clr;
  logic                    ack_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= '0;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_l = rst_sq[1];

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_pin
      eint_sync_edge #(.STAGES(SYNC)) u_edge (
        .clk     (clk),
        .rst_n   (rst_l),
        .pin_n_i (pin_n_i[g]),
        .en_i    (en_i[g]),
        .fall_o  (fall[g])
      );
    end
  endgenerate

  eint_regs #(
    .NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .TRACE_AD(TRACE_AD)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_l),
    .fall_i     (fall),
    .ack_clr_i  (ack_clr),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .pend_o     (pend_q),
    .trace_o    (trace_q),
    .lvl_flat_o (lvl_flat),
    .rdata_o    (rdata_o)
  );

  eint_arb #(.NSRC(NSRC), .LVL_W(LVL_W)) u_arb (
    .pend_i     (pend_q),
    .lvl_flat_i (lvl_flat),
    .ack_lvl_i  (ack_lvl_i),
    .max_lvl_o  (irq_lvl_o),
    .ack_hit_o  (ack_hit),
    .ack_sel_o  (ack_sel)
  );

  assign ack_clr   = ack_sel & {NSRC{ack_i}};
  assign vec_vld_o = ack_i & ack_hit;
  assign vec_o     = VEC_W'(VEC_L1 - 1) + VEC_W'(ack_lvl_i);
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk #(
  parameter int NSRC     = 8,
  parameter int LVL_W    = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int TRACE_AD = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_L1   = 25
) (
  input logic              clk,
  input logic              rst_l,
  input logic [NSRC-1:0]   en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [LVL_W-1:0]  irq_lvl_o,
  input logic              ack_i,
  input logic [LVL_W-1:0]  ack_lvl_i,
  input logic              vec_vld_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   trace_q
);
  assert_req_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_l)
    (irq_lvl_o != '0) |-> (pend_q != '0));

  assert_no_set_when_off_R2: assert property (@(posedge clk) disable iff (!rst_l)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_i)) == '0));

  assert_new_pend_traced_R1: assert property (@(posedge clk) disable iff (!rst_l)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~trace_q) == '0));

  assert_trace_kept_R5: assert property (@(posedge clk) disable iff (!rst_l)
    !(wr_en_i && (addr_i == ADDR_W'(TRACE_AD))) |=>
      ((trace_q & $past(trace_q)) == $past(trace_q)));

  assert_vec_match_R7: assert property (@(posedge clk) disable iff (!rst_l)
    vec_vld_o |-> (ack_i && (vec_o == VEC_W'(VEC_L1 - 1) + VEC_W'(ack_lvl_i))));

  assert_nmi_level_R3: assert property (@(posedge clk) disable iff (!rst_l)
    (addr_i == ADDR_W'(3)) |-> (rdata_o[6:4] == 3'b111));
endmodule

bind eint_ctrl eint_ctrl_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .TRACE_AD(TRACE_AD), .VEC_W(VEC_W), .VEC_L1(VEC_L1)
) u_chk (
  .clk       (clk),
  .rst_l     (rst_l),
  .en_i      (en_i),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .rdata_o   (rdata_o),
  .irq_lvl_o (irq_lvl_o),
  .ack_i     (ack_i),
  .ack_lvl_i (ack_lvl_i),
  .vec_vld_o (vec_vld_o),
  .vec_o     (vec_o),
  .pend_q    (pend_q),
  .trace_q   (trace_q)
);

// File: tb/eint_ctrl_bench.sv
module eint_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pin_n, en, wdata, rdata;
  logic [2:0] addr, irq_lvl, ack_lvl;
  logic       wr_en, ack, vec_vld;
  logic [7:0] vec;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eint_ctrl u_eint_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_n_i(pin_n), .en_i(en),
    .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata),
    .irq_lvl_o(irq_lvl), .ack_i(ack), .ack_lvl_i(ack_lvl),
    .vec_vld_o(vec_vld), .vec_o(vec)
  );

  // fields: [34:32] winner, [31:29] expected level, [28:21] pin mask, [20:0] levels l6..l0
  localparam logic [34:0] TBL [6] = '{
    {3'd1, 3'd3, 8'h06, {3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3, 3'd3}},
    {3'd4, 3'd6, 8'h34, {3'd0, 3'd6, 3'd6, 3'd0, 3'd5, 3'd0, 3'd0}},
    {3'd7, 3'd7, 8'h81, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd2}},
    {3'd3, 3'd7, 8'h88, {3'd0, 3'd0, 3'd0, 3'd7, 3'd0, 3'd0, 3'd0}},
    {3'd0, 3'd0, 8'h02, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0}},
    {3'd0, 3'd4, 8'h41, {3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd4}}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic get_pend(output logic [7:0] p);
    logic [7:0] d;
    for (int r = 0; r < 4; r++) begin
      rd(3'(r), d);
      p[2*r]   = d[3];
      p[2*r+1] = d[7];
    end
  endtask

  task automatic fire(input logic [7:0] m);
    @(negedge clk);
    pin_n = ~m;
    repeat (4) @(negedge clk);
    pin_n = 8'hFF;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_ack(input logic [2:0] l, output logic v, output logic [7:0] n);
    @(negedge clk);
    ack = 1'b1; ack_lvl = l;
    #1 v = vec_vld; n = vec;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, p, n;
    logic v;
    rst_n = 1'b0; pin_n = 8'hFF; en = 8'hFF; addr = '0; wr_en = 1'b0;
    wdata = '0; ack = 1'b0; ack_lvl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    rd(3'd0, d); check("R9 reg0 after reset", d, 8'h00);
    rd(3'd3, d); check("R9 reg3 after reset, R3 nmi level 7", d, 8'h70);
    rd(3'd4, d); check("R9 trace after reset", d, 8'h00);
    check("R9 irq level after reset", irq_lvl, 0);
    check("R9 vec_vld after reset", vec_vld, 0);

    // table walk: R3 R6 R7 R1 R5
    for (int e = 0; e < 6; e++) begin
      logic [20:0] lv;
      logic [7:0]  m, ep;
      logic [2:0]  el, w;
      lv = TBL[e][20:0]; m = TBL[e][28:21]; el = TBL[e][31:29]; w = TBL[e][34:32];
      for (int r = 0; r < 4; r++) begin
        logic [2:0] hi;
        hi = (r == 3) ? 3'd0 : lv[(2*r+1)*3 +: 3];
        wr(3'(r), {1'b0, hi, 1'b0, lv[(2*r)*3 +: 3]});
      end
      wr(3'd4, 8'h00);
      rd(3'd1, d); check("R3 level readback reg1", d, {1'b0, lv[9 +: 3], 1'b0, lv[6 +: 3]});
      fire(m);
      check("R6 highest pending level", irq_lvl, el);
      ep = m;
      if (el != 3'd0) begin
        do_ack(el, v, n);
        check("R7 vec_vld on ack", v, 1);
        check("R7 vector number", n, 24 + el);
        ep[w] = 1'b0;
      end
      get_pend(p); check("R7 pending after ack / R1 set", p, ep);
      rd(3'd4, d); check("R5 trace unaffected by ack", d, m);
    end

    // clear everything, set levels src0=3 src1=2
    wr(3'd0, 8'h23); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);

    // R2 disabled pin
    en = 8'hFE;
    fire(8'h01);
    get_pend(p); check("R2 disabled pin sets no pending", p, 8'h00);
    rd(3'd4, d); check("R2 disabled pin sets no trace", d, 8'h00);
    check("R2 disabled pin no request", irq_lvl, 0);
    en = 8'hFF;

    // R4 write one keeps, write zero clears, trace survives
    fire(8'h01);
    wr(3'd0, 8'h2B);
    get_pend(p); check("R4 write one keeps pending", p, 8'h01);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); check("R5 write one keeps trace", d, 8'h01);
    wr(3'd0, 8'h23);
    get_pend(p); check("R4 write zero clears pending", p, 8'h00);
    rd(3'd4, d); check("R5 trace survives pending clear", d, 8'h01);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R5 write zero clears trace", d, 8'h00);

    // R7 ack with no match
    fire(8'h01);
    do_ack(3'd5, v, n);
    check("R7 no match vec_vld low", v, 0);
    get_pend(p); check("R7 no match leaves pending", p, 8'h01);

    // R8 edge and ack in the same cycle (src0 pending at level 3)
    @(negedge clk); pin_n = 8'hFE;
    @(negedge clk);
    @(negedge clk); ack = 1'b1; ack_lvl = 3'd3;
    @(negedge clk); ack = 1'b0;
    pin_n = 8'hFF;
    get_pend(p); check("R8 edge beats ack", p, 8'h01);
    do_ack(3'd3, v, n);
    get_pend(p); check("R7 plain ack clears", p, 8'h00);

    // R8 edge and software clear in the same cycle
    fire(8'h01);
    @(negedge clk); pin_n = 8'hFE;
    @(negedge clk);
    wr(3'd0, 8'h23);
    pin_n = 8'hFF;
    get_pend(p); check("R8 edge beats write zero", p, 8'h01);
    wr(3'd0, 8'h23);

    // R1 held low: one edge, one pending
    @(negedge clk); pin_n = 8'hFD;
    repeat (5) @(negedge clk);
    check("R1 held pin requests", irq_lvl, 2);
    do_ack(3'd2, v, n);
    repeat (6) @(negedge clk);
    get_pend(p); check("R1 held pin does not re-set", p, 8'h00);
    check("R1 held pin no request", irq_lvl, 0);
    pin_n = 8'hFF;
    repeat (4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule